// File: doc/BRIEF.md
# Multicycle Processor Sequencer Control

This block is the controller of a processor datapath that runs each instruction over several short clock cycles. One ALU and one memory port serve every instruction, so the controller must say in every cycle what those units do. It is a Moore state machine: its only data input is the 6-bit opcode held in the instruction register, and every control output depends on the current state alone.

Every instruction starts with a fetch cycle and a decode cycle. In the fetch cycle the instruction is read and the PC is advanced by four. In the decode cycle the branch target is computed in advance, whether or not the instruction turns out to be a branch. The opcode then picks a path of its own length. A branch-equal finishes in its third cycle. An R-type operation and a store finish in their fourth cycle. A load finishes in its fifth cycle, when the value read from memory is written to the register file. An opcode the controller does not recognise goes straight back to fetch after decode.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) puts the controller in the fetch state, so the fetch pattern of R2 appears after that edge. The pattern stays while reset is held.
- R2: Fetch cycle: `mem_rd`=1, `addr_sel`=0 (PC), `ir_wr`=1, `alu_src_a`=0 (PC), `alu_src_b`=2'b01 (constant 4), `alu_op`=2'b00 (add), `pc_src`=2'b00 (ALU result), `pc_wr`=1. Every other output is 0.
- R3: The cycle after every fetch is decode: `alu_src_a`=0, `alu_src_b`=2'b11 (sign-extended immediate shifted left by 2), `alu_op`=2'b00. Every strobe is 0 (`pc_wr`, `pc_wr_cond`, `mem_rd`, `mem_wr`, `ir_wr`, `rf_wr`).
- R4: Opcode decoding: 6'h00 R-type, 6'h23 load, 6'h2B store, 6'h04 branch-equal. Any other opcode returns to fetch right after decode, so the instruction takes 2 cycles.
- R5: Branch-equal, third cycle: `alu_src_a`=1 (A), `alu_src_b`=2'b00 (B), `alu_op`=2'b01 (subtract/compare), `pc_wr_cond`=1, `pc_src`=2'b01 (ALUOut), `pc_wr`=0. Fetch follows, for 3 cycles in all.
- R6: Load or store, third cycle (address compute): `alu_src_a`=1, `alu_src_b`=2'b10 (sign-extended immediate), `alu_op`=2'b00. Every strobe is 0.
- R7: Load: the fourth cycle has `mem_rd`=1 and `addr_sel`=1 (ALUOut). The fifth cycle has `rf_wr`=1, `wreg_sel`=0 (rt) and `wdata_sel`=1 (memory data). Fetch follows, for 5 cycles in all.
- R8: Store: the fourth cycle has `mem_wr`=1 and `addr_sel`=1. Fetch follows, for 4 cycles in all.
- R9: R-type: the third cycle has `alu_src_a`=1, `alu_src_b`=2'b00 and `alu_op`=2'b10 (function field). The fourth cycle has `rf_wr`=1, `wreg_sel`=1 (rd) and `wdata_sel`=0 (ALUOut). Fetch follows, for 4 cycles in all.
- R10: `mem_rd` and `mem_wr` are never both 1. The memory is never accessed in a cycle that writes the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU reports equality |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| rf_wr | output | 1 | Register file write |
| wreg_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wdata_sel | output | 1 | Register write data: 0 ALUOut, 1 memory data |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU operand B: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALUOut |

## Verification
The bench runs every opcode class and checks the control pattern in each cycle, so the length of each path is checked as well. A controller that routed a store into the load write-back would give five cycles instead of four. One that moved the branch target into the wrong cycle would show a wrong `alu_src_b` in decode. Unknown opcodes 6'h02 and 6'h3F must return after two cycles; a decoder with an incomplete opcode match would send them into an execute path. A reset applied in the middle of a load must give the fetch pattern at the next edge, not the load write-back. Back-to-back instructions with different opcodes check that no state carries over between instructions.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared types and encodings for the multicycle sequencer.
// Assumes a 6-bit opcode field and 2-bit multiplexer selects.
package mc_ctrl_pkg;
    localparam int OP_W  = 6;
    localparam int SEL_W = 2;
    localparam int ST_W  = 4;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

    localparam logic [SEL_W-1:0] SRCB_REG  = 2'b00;
    localparam logic [SEL_W-1:0] SRCB_FOUR = 2'b01;
    localparam logic [SEL_W-1:0] SRCB_IMM  = 2'b10;
    localparam logic [SEL_W-1:0] SRCB_IMM4 = 2'b11;

    localparam logic [SEL_W-1:0] ALU_ADD   = 2'b00;
    localparam logic [SEL_W-1:0] ALU_SUB   = 2'b01;
    localparam logic [SEL_W-1:0] ALU_FUNCT = 2'b10;

    localparam logic [SEL_W-1:0] PCS_ALU    = 2'b00;
    localparam logic [SEL_W-1:0] PCS_ALUOUT = 2'b01;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_EXEC   = 4'd3,
        ST_BRANCH = 4'd4,
        ST_LDMEM  = 4'd5,
        ST_STMEM  = 4'd6,
        ST_RWB    = 4'd7,
        ST_LWB    = 4'd8
    } seq_state_t;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             addr_sel;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_wr;
        logic             rf_wr;
        logic             wreg_sel;
        logic             wdata_sel;
        logic             alu_src_a;
        logic [SEL_W-1:0] alu_src_b;
        logic [SEL_W-1:0] alu_op;
        logic [SEL_W-1:0] pc_src;
    } ctrl_word_t;
endpackage

// File: rtl/mc_state_reg.sv
// Module: state register of the sequencer.
// Assumes a synchronous active-low reset that forces the fetch state.
module mc_state_reg
    import mc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t nxt,
    output seq_state_t cur
);
    // Purpose: hold the current state and restart at fetch on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_FETCH;
        else        cur <= nxt;
    end

    // R1: any edge with reset low leaves the machine in fetch.
    assert_reset_fetch_R1: assert property (@(posedge clk)
        !rst_n |=> cur == ST_FETCH);
endmodule

// File: rtl/mc_next_state.sv
// Module: next-state logic. The opcode is read only in decode and in
// address compute; every other state has a fixed successor.
// Assumes the opcode is held stable for the whole instruction.
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_t      cur,
    input  logic [OP_W-1:0] opcode,
    output seq_state_t      nxt
);
    // Purpose: choose the successor state from the state and opcode.
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_RTYPE)                            nxt = ST_EXEC;
                else if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_ADDR;
                else if (opcode == OPC_BEQ)                         nxt = ST_BRANCH;
                else                                                nxt = ST_FETCH;
            end
            ST_ADDR:   nxt = (opcode == OPC_LOAD) ? ST_LDMEM : ST_STMEM;
            ST_EXEC:   nxt = ST_RWB;
            ST_LDMEM:  nxt = ST_LWB;
            default:   nxt = ST_FETCH;
        endcase
    end

    // R3: fetch is always followed by decode.
    assert_fetch_then_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_FETCH |=> cur == ST_DECODE);
    // R4: an unrecognised opcode leaves decode straight for fetch.
    assert_unknown_to_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_DECODE && opcode != OPC_RTYPE && opcode != OPC_LOAD &&
         opcode != OPC_STORE && opcode != OPC_BEQ) |=> cur == ST_FETCH);
    // R7: a load moves from address compute to the memory read.
    assert_load_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_ADDR && opcode == OPC_LOAD) |=> cur == ST_LDMEM);
endmodule

// File: rtl/mc_out_decode.sv
// Module: Moore output decoder, one control word per state.
// Assumes inactive selects default to zero.
module mc_out_decode
    import mc_ctrl_pkg::*;
(
    input  seq_state_t cur,
    output ctrl_word_t ctl
);
    // Purpose: map the state to the datapath control word.
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_src_b = SRCB_FOUR;
                ctl.alu_op    = ALU_ADD;
                ctl.pc_src    = PCS_ALU;
                ctl.pc_wr     = 1'b1;
            end
            ST_DECODE: begin
                ctl.alu_src_b = SRCB_IMM4;
                ctl.alu_op    = ALU_ADD;
            end
            ST_ADDR: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_IMM;
                ctl.alu_op    = ALU_ADD;
            end
            ST_EXEC: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_REG;
                ctl.alu_op    = ALU_FUNCT;
            end
            ST_BRANCH: begin
                ctl.alu_src_a  = 1'b1;
                ctl.alu_src_b  = SRCB_REG;
                ctl.alu_op     = ALU_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PCS_ALUOUT;
            end
            ST_LDMEM: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_STMEM: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_RWB: begin
                ctl.rf_wr    = 1'b1;
                ctl.wreg_sel = 1'b1;
            end
            ST_LWB: begin
                ctl.rf_wr     = 1'b1;
                ctl.wdata_sel = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    // Purpose: guard the single memory port against double use.
    always_comb begin
        assert_one_mem_R10: assert (!(ctl.mem_rd && ctl.mem_wr));
        assert_mem_vs_rf_R10: assert (!((ctl.mem_rd || ctl.mem_wr) && ctl.rf_wr));
    end
endmodule

// File: rtl/mc_seq_ctrl.sv
// Module: top of the multicycle sequencer control. Joins the state
// register, next-state logic and output decoder, and flattens the
// control word onto plain ports.
// Assumes opcode comes from the instruction register and is stable
// from decode until the instruction ends.
module mc_seq_ctrl
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             rf_wr,
    output logic             wreg_sel,
    output logic             wdata_sel,
    output logic             alu_src_a,
    output logic [SEL_W-1:0] alu_src_b,
    output logic [SEL_W-1:0] alu_op,
    output logic [SEL_W-1:0] pc_src
);
    seq_state_t cur_st;
    seq_state_t nxt_st;
    ctrl_word_t ctl;

    mc_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt_st),
        .cur   (cur_st)
    );

    mc_next_state u_next (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur    (cur_st),
        .opcode (opcode),
        .nxt    (nxt_st)
    );

    mc_out_decode u_dec (
        .cur (cur_st),
        .ctl (ctl)
    );

    // Purpose: drive the ports from the control word.
    always_comb begin
        pc_wr      = ctl.pc_wr;
        pc_wr_cond = ctl.pc_wr_cond;
        addr_sel   = ctl.addr_sel;
        mem_rd     = ctl.mem_rd;
        mem_wr     = ctl.mem_wr;
        ir_wr      = ctl.ir_wr;
        rf_wr      = ctl.rf_wr;
        wreg_sel   = ctl.wreg_sel;
        wdata_sel  = ctl.wdata_sel;
        alu_src_a  = ctl.alu_src_a;
        alu_src_b  = ctl.alu_src_b;
        alu_op     = ctl.alu_op;
        pc_src     = ctl.pc_src;
    end

    // R2: a PC increment is never repeated in consecutive cycles.
    assert_no_double_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr |=> !pc_wr && !ir_wr);
    // R3: the cycle after an instruction load computes the branch target.
    assert_decode_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (alu_src_b == SRCB_IMM4 && !alu_src_a && !mem_rd && !mem_wr));
    // R5: a conditional PC update ends the instruction.
    assert_branch_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> ir_wr);
    // R8: a store ends right after its memory write.
    assert_store_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_wr);
    // R9: a register-file write always ends the instruction.
    assert_wb_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> ir_wr);
endmodule

// File: tb/sim_mc_seq_ctrl.sv
module sim_mc_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
    logic       rf_wr, wreg_sel, wdata_sel, alu_src_a;
    logic [1:0] alu_src_b, alu_op, pc_src;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    mc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .rf_wr(rf_wr),
        .wreg_sel(wreg_sel), .wdata_sel(wdata_sel), .alu_src_a(alu_src_a),
        .alu_src_b(alu_src_b), .alu_op(alu_op), .pc_src(pc_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Control word order:
    // pc_wr pc_wr_cond addr_sel mem_rd mem_wr ir_wr rf_wr wreg_sel wdata_sel alu_src_a alu_src_b alu_op pc_src
    function automatic logic [15:0] cw(input logic pw, pc, as, mr, mw, iw, rw, ws, wd, sa,
                                       input logic [1:0] sb, op, ps);
        return {pw, pc, as, mr, mw, iw, rw, ws, wd, sa, sb, op, ps};
    endfunction

    localparam logic [15:0] E_FETCH = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00};
    localparam logic [15:0] E_DEC   = {10'b0,2'b11,2'b00,2'b00};
    localparam logic [15:0] E_ADDR  = {9'b0,1'b1,2'b10,2'b00,2'b00};
    localparam logic [15:0] E_EXEC  = {9'b0,1'b1,2'b00,2'b10,2'b00};
    localparam logic [15:0] E_BR    = {1'b0,1'b1,7'b0,1'b1,2'b00,2'b01,2'b01};
    localparam logic [15:0] E_LDMEM = {2'b0,1'b1,1'b1,12'b0};
    localparam logic [15:0] E_STMEM = {2'b0,1'b1,1'b0,1'b1,11'b0};
    localparam logic [15:0] E_RWB   = {6'b0,1'b1,1'b1,1'b0,7'b0};
    localparam logic [15:0] E_LWB   = {6'b0,1'b1,1'b0,1'b1,7'b0};

    function automatic logic [15:0] outs();
        return cw(pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, rf_wr,
                  wreg_sel, wdata_sel, alu_src_a, alu_src_b, alu_op, pc_src);
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        logic [15:0] got;
        got = outs();
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, got, exp);
        end
    endtask

    // Check the current cycle, then move to the next negative edge.
    task automatic step(input string tag, input logic [15:0] exp);
        check(tag, exp);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 held reset", E_FETCH);
        rst_n = 1'b1;
        check("R1 after release", E_FETCH);
    endtask

    task automatic t_rtype();
        opcode = 6'h00;
        step("R2 fetch", E_FETCH);
        step("R3 decode", E_DEC);
        step("R9 execute", E_EXEC);
        step("R9 write rd", E_RWB);
        check("R9 back to fetch", E_FETCH);
    endtask

    task automatic t_load();
        opcode = 6'h23;
        step("R2 fetch", E_FETCH);
        step("R3 decode", E_DEC);
        step("R6 load address", E_ADDR);
        step("R7 memory read", E_LDMEM);
        step("R7 write rt", E_LWB);
        check("R7 back to fetch", E_FETCH);
    endtask

    task automatic t_store();
        opcode = 6'h2B;
        step("R2 fetch", E_FETCH);
        step("R3 decode", E_DEC);
        step("R6 store address", E_ADDR);
        step("R8 memory write", E_STMEM);
        check("R8 back to fetch", E_FETCH);
    endtask

    task automatic t_branch();
        opcode = 6'h04;
        step("R2 fetch", E_FETCH);
        step("R3 decode", E_DEC);
        step("R5 branch", E_BR);
        check("R5 back to fetch", E_FETCH);
    endtask

    task automatic t_unknown(input logic [5:0] op);
        opcode = op;
        step("R2 fetch", E_FETCH);
        step("R3 decode", E_DEC);
        check("R4 unknown opcode returns", E_FETCH);
    endtask

    task automatic t_reset_midway();
        opcode = 6'h23;
        step("R2 fetch", E_FETCH);
        step("R3 decode", E_DEC);
        step("R6 load address", E_ADDR);
        check("R7 memory read", E_LDMEM);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-load", E_FETCH);
        rst_n = 1'b1;
    endtask

    task automatic t_memory_exclusive();
        logic bad;
        bad = 1'b0;
        opcode = 6'h2B;
        for (int i = 0; i < 4; i++) begin
            if ((mem_rd && mem_wr) || ((mem_rd || mem_wr) && rf_wr)) bad = 1'b1;
            @(negedge clk);
        end
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL R10 memory strobe overlap: actual 1 expected 0");
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_rtype();
        t_load();
        t_store();
        t_branch();
        t_unknown(6'h02);
        t_unknown(6'h3F);
        t_branch();
        t_load();
        t_rtype();
        t_store();
        t_reset_midway();
        t_memory_exclusive();
        check("R2 fetch after store", E_FETCH);
        t_load();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule